// File: doc/BRIEF.md
# Resynchronizing Programmable-Bit-Time Serial Receiver

This block receives bytes from a single-wire line that rests high. The internal sample clock runs at half the rate of the block clock. The length of one bit is a programmable count of sample-clock periods. For example, a 4 MHz sample clock and a count of 416 give roughly 9,615 bit/s.

The raw line passes through a two-flop synchronizer and then a digital glitch filter. The filter ticks at the sample rate divided by a programmable prescaler. It accepts a new line level only after that level has held for 16 consecutive filter ticks.

A falling edge on the filtered line starts a frame. The first sample is taken half a bit count after that edge, rounded down. Each further sample follows one full bit count after the one before. Every later falling edge inside the frame reloads the half-bit offset, so timing drift between transmitter and receiver is cleared at every such edge. A frame holds one start bit, eight data bits sent least significant first, and one stop bit. The block reports either a finished byte with a one-cycle strobe or a one-cycle framing-error pulse.

Top module: `resync_rx`

## Requirements
- R1: A sample tick occurs on every second block-clock cycle, starting with the second cycle after reset is released. All bit timing is counted in sample ticks.
- R2: The filtered line takes a new level only after the synchronized input has differed from it on 16 consecutive filter ticks, so shorter pulses are ignored. A filter tick is every Nth sample tick, where N is `prescale`; a value of 0 or 1 means every sample tick.
- R3: While idle, a falling edge of the filtered line starts a frame, and the start bit is sampled floor(bitTime/2) sample ticks later.
- R4: Each later bit of the frame is sampled exactly `bitTime` sample ticks after the previous sample.
- R5: Any falling edge of the filtered line during a frame reloads the half-bit offset, and the next sample is taken floor(bitTime/2) ticks after that edge. This lets a transmitter running between 15 % slower and 15 % faster still deliver a 0x55 byte correctly.
- R6: Data bits are collected least significant bit first. If the stop bit samples high, `dataOut` shows the byte and `dataValid` is high for exactly one cycle, one cycle after the stop sample.
- R7: If the stop bit samples low, `frameErr` is high for one cycle instead, `dataValid` stays low, and the block returns to idle.
- R8: If the start bit samples high, the frame is dropped with no output pulse, and the next falling edge starts a fresh frame.
- R9: During and after reset the outputs are low, the block is idle, and the filtered line is taken as high.
- R10: A `bitTime` below 4 acts as 4. For example, with `bitTime` = 1 a line held low for 40 ticks gives exactly one framing error and no byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; the sample clock is half of it |
| rstN | input | 1 | Active-low synchronous reset |
| rxIn | input | 1 | Serial line, idle high, asynchronous |
| bitTime | input | CNT_W (16) | Bit length in sample ticks |
| prescale | input | PRE_W (8) | Filter tick divider; 0 and 1 mean no division |
| dataOut | output | DATA_W (8) | Last byte received with a high stop bit |
| dataValid | output | 1 | One-cycle strobe for a new byte |
| frameErr | output | 1 | One-cycle strobe when a stop bit is sampled low |

## Verification
A wrong bit counter, or a half-bit offset that is lost, shows up at the ports within a single frame. The strobe then lands on the wrong cycle, or the byte is shifted by one position. A filter run counter that fails to clear lets a glitch through, and a spurious frame or framing error follows about ten bit times later. Because the reference model is compared with the outputs on every clock, a one-cycle shift of any strobe is reported in the cycle it occurs. Byte-level checks separately confirm that skewed transmitters are still received correctly, which depends on the realignment at each falling edge.

// File: rtl/resync_rx_pkg.sv
package resync_rx_pkg;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_FRAME = 1'b1
  } rxState_e;

  // strobes from control to datapath, valid for one block-clock cycle
  typedef struct packed {
    logic shiftIn;   // capture filtered line as next data bit
    logic emitByte;  // stop bit high: publish byte
    logic emitErr;   // stop bit low: raise framing error
  } rxStrobe_t;

endpackage

// File: rtl/rx_filter.sv
module rx_filter #(
  parameter int PRE_W    = 8,
  parameter int FILT_LEN = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleEn,
  input  logic [PRE_W-1:0] prescale,
  input  logic             rawLine,
  output logic             filtLine
);
  localparam int RUN_W = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(FILT_LEN - 1);
  localparam logic [PRE_W-1:0] PRE_ONE  = PRE_W'(1);

  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preLast;
  logic [RUN_W-1:0] runCnt;
  logic             filtTick;

  always_comb begin
    preLast  = (prescale == '0) ? '0 : (prescale - PRE_ONE);
    filtTick = sampleEn && (preCnt >= preLast);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (sampleEn) begin
      preCnt <= (preCnt >= preLast) ? '0 : (preCnt + PRE_ONE);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      filtLine <= 1'b1;
      runCnt   <= '0;
    end else if (filtTick) begin
      if (rawLine == filtLine) begin
        runCnt <= '0;
      end else if (runCnt == RUN_LAST) begin
        filtLine <= rawLine;
        runCnt   <= '0;
      end else begin
        runCnt <= runCnt + RUN_W'(1);
      end
    end
  end
endmodule

// File: rtl/rx_datapath.sv
module rx_datapath import resync_rx_pkg::*; #(
  parameter int PRE_W      = 8,
  parameter int DATA_W     = 8,
  parameter int FILT_LEN   = 16,
  parameter int SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxIn,
  input  logic [PRE_W-1:0]  prescale,
  input  rxStrobe_t         strobe,
  output logic              sampleEn,
  output logic              syncLine,
  output logic              filtLine,
  output logic              fallEdge,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataValid,
  output logic              frameErr
);
  logic [SYNC_DEPTH-1:0] syncQ;
  logic                  sampleDiv;
  logic                  filtPrev;
  logic [DATA_W-1:0]     shiftReg;

  // synchronizer, resets to the idle level
  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_DEPTH-2:0], rxIn};
  end
  assign syncLine = syncQ[SYNC_DEPTH-1];

  // half-rate sample tick
  always_ff @(posedge clk) begin
    if (!rstN) sampleDiv <= 1'b0;
    else       sampleDiv <= ~sampleDiv;
  end
  assign sampleEn = sampleDiv;

  rx_filter #(.PRE_W(PRE_W), .FILT_LEN(FILT_LEN)) uFilter (
    .clk      (clk),
    .rstN     (rstN),
    .sampleEn (sampleEn),
    .prescale (prescale),
    .rawLine  (syncLine),
    .filtLine (filtLine)
  );

  always_ff @(posedge clk) begin
    if (!rstN)         filtPrev <= 1'b1;
    else if (sampleEn) filtPrev <= filtLine;
  end
  assign fallEdge = sampleEn && filtPrev && !filtLine;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg  <= '0;
      dataOut   <= '0;
      dataValid <= 1'b0;
      frameErr  <= 1'b0;
    end else begin
      if (strobe.shiftIn) shiftReg <= {filtLine, shiftReg[DATA_W-1:1]};
      if (strobe.emitByte) dataOut <= shiftReg;
      dataValid <= strobe.emitByte;
      frameErr  <= strobe.emitErr;
    end
  end
endmodule

// File: rtl/rx_control.sv
module rx_control import resync_rx_pkg::*; #(
  parameter int CNT_W    = 16,
  parameter int DATA_W   = 8,
  parameter int MIN_TIME = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleEn,
  input  logic             fallEdge,
  input  logic             filtLine,
  input  logic [CNT_W-1:0] bitTime,
  output rxStrobe_t        strobe
);
  localparam int LAST_IDX = DATA_W + 1;
  localparam int IDX_W    = $clog2(LAST_IDX + 1);
  localparam logic [CNT_W-1:0] TIME_FLOOR = CNT_W'(MIN_TIME);
  localparam logic [CNT_W-1:0] CNT_ONE    = CNT_W'(1);
  localparam logic [IDX_W-1:0] IDX_LAST   = IDX_W'(LAST_IDX);

  rxState_e         state;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] bitIdx;
  logic [CNT_W-1:0] effTime;
  logic [CNT_W-1:0] halfTime;
  logic             samplePt;
  logic             isStart;
  logic             isStop;

  always_comb begin
    effTime  = (bitTime < TIME_FLOOR) ? TIME_FLOOR : bitTime;
    halfTime = effTime >> 1;
    samplePt = sampleEn && (state == ST_FRAME) && !fallEdge && (cnt == CNT_ONE);
    isStart  = (bitIdx == '0);
    isStop   = (bitIdx == IDX_LAST);
    strobe.shiftIn  = samplePt && !isStart && !isStop;
    strobe.emitByte = samplePt && isStop && filtLine;
    strobe.emitErr  = samplePt && isStop && !filtLine;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      bitIdx <= '0;
    end else if (sampleEn) begin
      if (fallEdge) begin
        cnt <= halfTime;                 // realign on every falling edge
        if (state == ST_IDLE) begin
          state  <= ST_FRAME;
          bitIdx <= '0;
        end
      end else if (state == ST_FRAME) begin
        if (cnt == CNT_ONE) begin
          cnt <= effTime;
          if ((isStart && filtLine) || isStop) state <= ST_IDLE;
          else bitIdx <= bitIdx + IDX_W'(1);
        end else begin
          cnt <= cnt - CNT_ONE;
        end
      end
    end
  end
endmodule

// File: rtl/resync_rx.sv
module resync_rx import resync_rx_pkg::*; #(
  parameter int CNT_W    = 16,
  parameter int PRE_W    = 8,
  parameter int DATA_W   = 8,
  parameter int FILT_LEN = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxIn,
  input  logic [CNT_W-1:0]  bitTime,
  input  logic [PRE_W-1:0]  prescale,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataValid,
  output logic              frameErr
);
  logic      sampleEn;
  logic      syncLine;
  logic      filtLine;
  logic      fallEdge;
  rxStrobe_t strobe;

  rx_datapath #(.PRE_W(PRE_W), .DATA_W(DATA_W), .FILT_LEN(FILT_LEN), .SYNC_DEPTH(2)) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .rxIn      (rxIn),
    .prescale  (prescale),
    .strobe    (strobe),
    .sampleEn  (sampleEn),
    .syncLine  (syncLine),
    .filtLine  (filtLine),
    .fallEdge  (fallEdge),
    .dataOut   (dataOut),
    .dataValid (dataValid),
    .frameErr  (frameErr)
  );

  rx_control #(.CNT_W(CNT_W), .DATA_W(DATA_W), .MIN_TIME(4)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .sampleEn (sampleEn),
    .fallEdge (fallEdge),
    .filtLine (filtLine),
    .bitTime  (bitTime),
    .strobe   (strobe)
  );
endmodule

// File: rtl/resync_rx_chk.sv
module resync_rx_chk (
  input logic clk,
  input logic rstN,
  input logic sampleEn,
  input logic syncLine,
  input logic filtLine,
  input logic dataValid,
  input logic frameErr
);
  // R1: sample ticks never fall on two cycles in a row
  assert_half_rate_R1: assert property (@(posedge clk) disable iff (!rstN)
    sampleEn |=> !sampleEn);

  // R2: the filtered line only ever moves to the synchronized level
  assert_filter_target_R2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(filtLine) |-> (filtLine == $past(syncLine)));

  // R6: a byte strobe follows a high stop sample taken on a tick
  assert_byte_on_high_stop_R6: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |-> ($past(filtLine) && $past(sampleEn)));

  // R6: byte strobe lasts one cycle
  assert_byte_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |=> !dataValid);

  // R7: framing error follows a low stop sample and excludes the byte strobe
  assert_err_on_low_stop_R7: assert property (@(posedge clk) disable iff (!rstN)
    frameErr |-> (!$past(filtLine) && $past(sampleEn) && !dataValid));
endmodule

bind resync_rx resync_rx_chk chk (
  .clk       (clk),
  .rstN      (rstN),
  .sampleEn  (sampleEn),
  .syncLine  (syncLine),
  .filtLine  (filtLine),
  .dataValid (dataValid),
  .frameErr  (frameErr)
);

// File: tb/tb_resync_rx.sv
`timescale 1ns/1ps
module tb_resync_rx;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rxIn = 1'b1;
  logic [15:0] bitTime = 16'd40;
  logic [7:0]  prescale = 8'd1;
  logic [7:0]  dataOut;
  logic        dataValid;
  logic        frameErr;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int errSeen = 0;
  int printed = 0;
  logic [7:0] gotQ[$];

  always #4 clk = ~clk;

  resync_rx dut (
    .clk(clk), .rstN(rstN), .rxIn(rxIn), .bitTime(bitTime), .prescale(prescale),
    .dataOut(dataOut), .dataValid(dataValid), .frameErr(frameErr)
  );

  // behavioural reference, evaluated once per block clock
  int  mS1, mS2, mDiv, mPre, mFilt, mRun, mPrev, mFrame, mCnt, mIdx, mShift;
  int  mValid, mErr, mData;
  int  sEn, fTick, fall, samp, effPre, eff, half;

  always @(posedge clk) begin
    if (!rstN) begin
      mS1 = 1; mS2 = 1; mDiv = 0; mPre = 0; mFilt = 1; mRun = 0; mPrev = 1;
      mFrame = 0; mCnt = 0; mIdx = 0; mShift = 0; mValid = 0; mErr = 0; mData = 0;
    end else begin
      sEn    = mDiv;
      effPre = (prescale == 0) ? 1 : int'(prescale);
      fTick  = (sEn != 0 && mPre >= effPre - 1) ? 1 : 0;
      fall   = (sEn != 0 && mPrev == 1 && mFilt == 0) ? 1 : 0;
      eff    = (bitTime < 4) ? 4 : int'(bitTime);
      half   = eff / 2;
      samp   = (sEn != 0 && mFrame == 1 && fall == 0 && mCnt == 1) ? 1 : 0;
      mValid = (samp == 1 && mIdx == 9 && mFilt == 1) ? 1 : 0;
      mErr   = (samp == 1 && mIdx == 9 && mFilt == 0) ? 1 : 0;
      if (mValid == 1) mData = mShift;
      if (samp == 1 && mIdx >= 1 && mIdx <= 8) mShift = (mShift >> 1) | (mFilt << 7);
      if (sEn == 1) begin
        if (fall == 1) begin
          mCnt = half;
          if (mFrame == 0) begin mFrame = 1; mIdx = 0; end
        end else if (mFrame == 1) begin
          if (mCnt == 1) begin
            mCnt = eff;
            if ((mIdx == 0 && mFilt == 1) || mIdx == 9) mFrame = 0;
            else mIdx = mIdx + 1;
          end else mCnt = mCnt - 1;
        end
        mPrev = mFilt;
      end
      if (fTick == 1) begin
        if (mS2 == mFilt) mRun = 0;
        else if (mRun == 15) begin mFilt = mS2; mRun = 0; end
        else mRun = mRun + 1;
      end
      if (sEn == 1) mPre = (mPre >= effPre - 1) ? 0 : mPre + 1;
      mS2 = mS1; mS1 = int'(rxIn); mDiv = 1 - mDiv;
    end
  end

  // per-clock comparison and event capture (R1 to R10 timing)
  always @(negedge clk) begin
    if (rstN) begin
      checks++;
      if (dataValid !== mValid[0] || frameErr !== mErr[0] || dataOut !== mData[7:0]) begin
        fails++;
        if (printed < 10) begin
          printed++;
          $display("FAIL R6 R7 model compare at cycle %0d: got v=%0b e=%0b d=%h, expected v=%0b e=%0b d=%h",
                   cyc, dataValid, frameErr, dataOut, mValid[0], mErr[0], mData[7:0]);
        end
      end
      if (dataValid) gotQ.push_back(dataOut);
      if (frameErr) errSeen++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog: got %0d cycles, expected under 150000", cyc);
      $display("  Result: errors=%0d of %0d checks", fails, checks);
      $finish;
    end
  end

  task automatic holdTicks(input logic v, input int ticks);
    rxIn = v;
    repeat (2 * ticks) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [7:0] b, input int tpb, input logic stopV);
    holdTicks(1'b0, tpb);
    for (int i = 0; i < 8; i++) holdTicks(b[i], tpb);
    holdTicks(stopV, tpb);
    holdTicks(1'b1, 3 * tpb);
  endtask

  task automatic expectByte(input string req, input logic [7:0] exp);
    checks++;
    if (gotQ.size() != 1 || gotQ[0] !== exp || errSeen != 0) begin
      fails++;
      $display("FAIL %s: got %0d bytes first=%h errs=%0d, expected one byte %h no errs",
               req, gotQ.size(), (gotQ.size() > 0) ? gotQ[0] : 8'h00, errSeen, exp);
    end
    gotQ.delete(); errSeen = 0;
  endtask

  task automatic expectNone(input string req, input int expErr);
    checks++;
    if (gotQ.size() != 0 || errSeen != expErr) begin
      fails++;
      $display("FAIL %s: got %0d bytes and %0d errs, expected 0 bytes and %0d errs",
               req, gotQ.size(), errSeen, expErr);
    end
    gotQ.delete(); errSeen = 0;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    checks++;  // R9 reset state
    if (dataValid !== 1'b0 || frameErr !== 1'b0 || dataOut !== 8'h00) begin
      fails++;
      $display("FAIL R9: got v=%0b e=%0b d=%h, expected 0 0 00", dataValid, frameErr, dataOut);
    end
    rstN = 1'b1;
    holdTicks(1'b1, 30);
    expectNone("R9 idle after reset", 0);

    sendFrame(8'h55, 40, 1'b1); expectByte("R3 R6 byte 55", 8'h55);
    sendFrame(8'h00, 40, 1'b1); expectByte("R4 byte 00", 8'h00);
    sendFrame(8'hFF, 40, 1'b1); expectByte("R4 byte FF", 8'hFF);
    sendFrame(8'hA3, 40, 1'b1); expectByte("R6 byte A3 lsb first", 8'hA3);

    sendFrame(8'h3C, 40, 1'b0); expectNone("R7 low stop", 1);

    holdTicks(1'b0, 15); holdTicks(1'b1, 60);
    expectNone("R2 15-tick glitch idle", 0);

    holdTicks(1'b0, 40); holdTicks(1'b1, 135); holdTicks(1'b0, 10); holdTicks(1'b1, 335);
    expectByte("R2 glitch inside FF", 8'hFF);

    holdTicks(1'b0, 18); holdTicks(1'b1, 100);
    expectNone("R8 false start", 0);
    sendFrame(8'h81, 40, 1'b1); expectByte("R8 next frame", 8'h81);

    sendFrame(8'h55, 46, 1'b1); expectByte("R5 slow transmitter", 8'h55);
    sendFrame(8'h55, 34, 1'b1); expectByte("R5 fast transmitter", 8'h55);

    bitTime = 16'd41;
    sendFrame(8'h96, 41, 1'b1); expectByte("R3 odd count", 8'h96);

    bitTime = 16'd80; prescale = 8'd2;
    holdTicks(1'b1, 20);
    holdTicks(1'b0, 20); holdTicks(1'b1, 100);
    expectNone("R2 prescaled glitch", 0);
    sendFrame(8'h5A, 80, 1'b1); expectByte("R2 R4 prescaled byte", 8'h5A);

    prescale = 8'd1; bitTime = 16'd1;
    holdTicks(1'b1, 20);
    sendFrame(8'h00, 40, 1'b0); expectNone("R10 clamped count", 1);

    bitTime = 16'd40;
    holdTicks(1'b1, 20);
    sendFrame(8'hC7, 40, 1'b1); expectByte("R1 R4 final byte", 8'hC7);

    $display("  Result: errors=%0d of %0d checks", fails, checks);
    $finish;
  end
endmodule